// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block drives an 8-bit multiplexed address/data memory bus from a CPU-side request port. A free-running counter divides time into machine cycles of twelve clock periods, where one clock period stands for one oscillator period. Every strobe edge sits at a fixed phase of that count. Each machine cycle carries one access: an instruction fetch, an external data read, an external data write, or nothing.

Between accesses the low address byte and the data share one bidirectional port, exposed as separate out, in and output-enable pins. The high address byte has its own port. An external address latch is expected to capture the low byte on the falling edge of the latch enable. Requests are taken only in the last phase of a machine cycle, and the accepted access fills the whole next cycle. A fetch that falls inside the internal program space is acknowledged but never reaches the bus.

Top module: `mem_bus_seq`

## Requirements
- R1: While rst_ni is low, the outputs are ale_o=0, psen_no=rd_no=wr_no=1, ad_oe_o=0, rvalid_o=0 and ack_o=0. The first clock edge after release starts phase 0 of a machine cycle.
- R2: In idle and fetch cycles, ale_o is high in phases 0-1 and 6-7 of the twelve-phase cycle and low in all other phases.
- R3: In a data read or write cycle, ale_o is high only in phases 0-1, so the second pulse is skipped. It rises again in phase 0 of the next cycle, one period after the data strobe returns high.
- R4: In an external fetch cycle, psen_no is low in phases 3-5 and 9-11. The port drives the low address byte in phases 0-2 and 6-8 and is released (ad_oe_o=0) while psen_no is low.
- R5: An external fetch samples ad_i at the clock edge that ends phase 5 and presents it on rdata_o with rvalid_o high for phase 6 only. The byte on the bus during the second strobe is discarded.
- R6: A fetch is internal when ea_i=1 and the address is below 8192. Such a fetch is acknowledged, but its cycle has no psen_no pulse, no port drive and no rvalid_o.
- R7: In a data read cycle, rd_no is low in phases 5-10. The port drives the low address byte in phases 0-2 and is released in phases 3-11. ad_i is sampled at the edge that ends phase 10, and rvalid_o is high in phase 11.
- R8: In a data write cycle, wr_no is low in phases 5-10. The port is driven in all twelve phases: the low address byte in phases 0-3 and wdata in phases 4-11.
- R9: During every external fetch, read and write cycle, ahi_o carries bits 15:8 of that access's address. An internal fetch or an idle cycle leaves it unchanged.
- R10: ack_o is high exactly in phase 11 while req_i is high. The acknowledged access fills the next machine cycle. Encoding of op_i: 2'b00 and 2'b01 mean fetch, 2'b10 means data read, 2'b11 means data write.
- R11: A cycle with no accepted request keeps the latch-enable pulses of R2, keeps every strobe high and leaves the port released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one oscillator period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ack_o |
| op_i | input | 2 | Access kind (see R10) |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Write data |
| ea_i | input | 1 | High lets low fetch addresses be served internally |
| ack_o | output | 1 | Request accepted (phase 11) |
| rdata_o | output | 8 | Read or fetch data |
| rvalid_o | output | 1 | One-period pulse, rdata_o valid |
| ale_o | output | 1 | Address latch enable |
| psen_no | output | 1 | Program read strobe, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| ad_o | output | 8 | Shared port, outgoing value |
| ad_oe_o | output | 1 | Shared port drive enable |
| ad_i | input | 8 | Shared port, incoming value |
| ahi_o | output | 8 | High address byte port |

## Verification
In phase 11 of a data read, the sequencer has to do two things in the same period: return the read byte with rvalid_o, and acknowledge the next request. The bench provokes this by keeping req_i high with a write queued behind the read. It then checks in that single phase that rvalid_o, rdata_o and ack_o are all correct. In the following cycle it checks that the write's strobes and its port drive follow with no lost phase, and that ale_o rises exactly one period after rd_no returns high.

// File: rtl/mbs_pkg.sv
`timescale 1ns/1ps
package mbs_pkg;
  localparam int MC_LEN   = 12;
  localparam int HALF_LEN = MC_LEN / 2;
  localparam int ALE_LEN  = 2;
  localparam int PS_LEAD  = 1;   // latch-enable fall to program strobe
  localparam int XS_LEAD  = 3;   // latch-enable fall to data strobe
  localparam int WD_LEAD  = 7;   // write data ahead of strobe rise
  localparam int PH_W     = $clog2(MC_LEN);

  typedef logic [PH_W-1:0] phase_t;

  localparam phase_t P_LAST     = phase_t'(MC_LEN - 1);
  localparam phase_t P_HALF     = phase_t'(HALF_LEN);
  localparam phase_t P_ALE_END  = phase_t'(ALE_LEN);
  localparam phase_t P_ADR_LAST = phase_t'(ALE_LEN);
  localparam phase_t P_PS_FIRST = phase_t'(ALE_LEN + PS_LEAD);
  localparam phase_t P_XS_FIRST = phase_t'(ALE_LEN + XS_LEAD);
  localparam phase_t P_XS_LAST  = phase_t'(ALE_LEN + XS_LEAD + HALF_LEN - 1);
  localparam phase_t P_WD_FIRST = phase_t'(ALE_LEN + XS_LEAD + HALF_LEN - WD_LEAD);

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_INT,
    ACC_FETCH,
    ACC_READ,
    ACC_WRITE
  } acc_e;
endpackage

// File: rtl/mbs_phase_ctr.sv
`timescale 1ns/1ps
module mbs_phase_ctr
  import mbs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_t phase_o,
  output logic   live_o,
  output logic   last_o
);
  phase_t phase_q;
  logic   live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      live_q  <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (live_q) phase_q <= (phase_q == P_LAST) ? '0 : phase_q + 1'b1;
    end
  end

  assign phase_o = phase_q;
  assign live_o  = live_q;
  assign last_o  = live_q && (phase_q == P_LAST);
endmodule

// File: rtl/mbs_accept.sv
`timescale 1ns/1ps
module mbs_accept
  import mbs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int INT_LIMIT = 8192
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 last_i,
  input  logic                 req_i,
  input  logic [1:0]           op_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 ea_i,
  output logic                 ack_o,
  output acc_e                 acc_o,
  output logic [DATA_W-1:0]    addr_lo_o,
  output logic [DATA_W-1:0]    wdata_o,
  output logic [ADDR_W-DATA_W-1:0] ahi_o
);
  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(INT_LIMIT);

  acc_e              kind, acc_q;
  logic [DATA_W-1:0] alo_q, wd_q;
  logic [HI_W-1:0]   ahi_q;

  always_comb begin
    if (op_i[1])                                kind = op_i[0] ? ACC_WRITE : ACC_READ;
    else if (ea_i && ({1'b0, addr_i} < LIMIT))  kind = ACC_INT;
    else                                        kind = ACC_FETCH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= ACC_IDLE;
      alo_q <= '0;
      wd_q  <= '0;
      ahi_q <= '0;
    end else if (last_i) begin
      acc_q <= req_i ? kind : ACC_IDLE;
      if (req_i) begin
        alo_q <= addr_i[DATA_W-1:0];
        wd_q  <= wdata_i;
        if (kind != ACC_INT) ahi_q <= addr_i[ADDR_W-1:DATA_W];
      end
    end
  end

  assign ack_o     = last_i && req_i;
  assign acc_o     = acc_q;
  assign addr_lo_o = alo_q;
  assign wdata_o   = wd_q;
  assign ahi_o     = ahi_q;
endmodule

// File: rtl/mbs_strobes.sv
`timescale 1ns/1ps
module mbs_strobes
  import mbs_pkg::*;
(
  input  logic   live_i,
  input  phase_t phase_i,
  input  acc_e   acc_i,
  output logic   ale_o,
  output logic   psen_no,
  output logic   rd_no,
  output logic   wr_no,
  output logic   ad_oe_o,
  output logic   sel_data_o,
  output logic   cap_o
);
  logic   second, is_data, in_xs;
  phase_t hp;

  always_comb begin
    second  = phase_i >= P_HALF;
    hp      = second ? phase_i - P_HALF : phase_i;
    is_data = (acc_i == ACC_READ) || (acc_i == ACC_WRITE);
    in_xs   = (phase_i >= P_XS_FIRST) && (phase_i <= P_XS_LAST);

    ale_o   = live_i && (hp < P_ALE_END) && !(is_data && second);
    psen_no = !((acc_i == ACC_FETCH) && (hp >= P_PS_FIRST));
    rd_no   = !((acc_i == ACC_READ) && in_xs);
    wr_no   = !((acc_i == ACC_WRITE) && in_xs);

    unique case (acc_i)
      ACC_FETCH: ad_oe_o = hp <= P_ADR_LAST;
      ACC_READ:  ad_oe_o = phase_i <= P_ADR_LAST;
      ACC_WRITE: ad_oe_o = 1'b1;
      default:   ad_oe_o = 1'b0;
    endcase

    sel_data_o = (acc_i == ACC_WRITE) && (phase_i >= P_WD_FIRST);
    // capture on the edge where the first fetch strobe or the read strobe rises
    cap_o = ((acc_i == ACC_FETCH) && (phase_i == P_HALF - 1'b1)) ||
            ((acc_i == ACC_READ)  && (phase_i == P_XS_LAST));
  end
endmodule

// File: rtl/mbs_port.sv
`timescale 1ns/1ps
module mbs_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_data_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] addr_lo_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= cap_i;
      if (cap_i) rdata_q <= ad_i;
    end
  end

  assign ad_o     = sel_data_i ? wdata_i : addr_lo_i;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/mem_bus_seq.sv
`timescale 1ns/1ps
module mem_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int INT_LIMIT = 8192
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic [1:0]               op_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic                     ea_i,
  output logic                     ack_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rvalid_o,
  output logic                     ale_o,
  output logic                     psen_no,
  output logic                     rd_no,
  output logic                     wr_no,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  input  logic [DATA_W-1:0]        ad_i,
  output logic [ADDR_W-DATA_W-1:0] ahi_o
);
  phase_t            phase;
  logic              live, last, sel_data, cap;
  acc_e              acc;
  logic [DATA_W-1:0] alo, wd;

  mbs_phase_ctr u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase),
    .live_o  (live),
    .last_o  (last)
  );

  mbs_accept #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .INT_LIMIT (INT_LIMIT)
  ) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .last_i    (last),
    .req_i     (req_i),
    .op_i      (op_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .ea_i      (ea_i),
    .ack_o     (ack_o),
    .acc_o     (acc),
    .addr_lo_o (alo),
    .wdata_o   (wd),
    .ahi_o     (ahi_o)
  );

  mbs_strobes u_stb (
    .live_i     (live),
    .phase_i    (phase),
    .acc_i      (acc),
    .ale_o      (ale_o),
    .psen_no    (psen_no),
    .rd_no      (rd_no),
    .wr_no      (wr_no),
    .ad_oe_o    (ad_oe_o),
    .sel_data_o (sel_data),
    .cap_o      (cap)
  );

  mbs_port #(.DATA_W(DATA_W)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_data_i (sel_data),
    .cap_i      (cap),
    .addr_lo_i  (alo),
    .wdata_i    (wd),
    .ad_i       (ad_i),
    .ad_o       (ad_o),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );
endmodule

// File: rtl/mem_bus_seq_chk.sv
`timescale 1ns/1ps
module mem_bus_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ack_o,
  input logic              rvalid_o,
  input logic              ale_o,
  input logic              psen_no,
  input logic              rd_no,
  input logic              wr_no,
  input logic [DATA_W-1:0] ad_o,
  input logic              ad_oe_o
);
  assert_strobe_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!psen_no, !rd_no, !wr_no}) <= 1);

  assert_ale_width_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> $past(ale_o, 2));

  assert_ale_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> !ale_o);

  assert_ale_after_rd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_no) |=> ale_o);

  assert_port_free_psen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_no |-> !ad_oe_o);

  assert_port_free_rd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o);

  assert_rvalid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  assert_rvalid_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (!$past(psen_no) || !$past(rd_no)));

  assert_wdata_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_no && !$past(wr_no)) |-> ($stable(ad_o) && ad_oe_o));

  assert_ack_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && req_i) |=> ale_o);
endmodule

bind mem_bus_seq mem_bus_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .ack_o    (ack_o),
  .rvalid_o (rvalid_o),
  .ale_o    (ale_o),
  .psen_no  (psen_no),
  .rd_no    (rd_no),
  .wr_no    (wr_no),
  .ad_o     (ad_o),
  .ad_oe_o  (ad_oe_o)
);

// File: tb/mem_bus_seq_bench.sv
`timescale 1ns/1ps
module mem_bus_seq_bench;
  localparam int K_IDLE = 0, K_INT = 1, K_FETCH = 2, K_READ = 3, K_WRITE = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ea = 1'b0;
  logic [7:0]  ad_in = '0;
  logic        ack, rvalid, ale, psen_n, rd_n, wr_n, ad_oe;
  logic [7:0]  rdata, ad_out, ahi;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  logic [7:0] last_hi = 8'h00;

  always #2.5 clk = ~clk;

  mem_bus_seq u_mem_bus_seq (
    .clk_i (clk), .rst_ni (rst_ni), .req_i (req), .op_i (op), .addr_i (addr),
    .wdata_i (wdata), .ea_i (ea), .ack_o (ack), .rdata_o (rdata), .rvalid_o (rvalid),
    .ale_o (ale), .psen_no (psen_n), .rd_no (rd_n), .wr_no (wr_n), .ad_o (ad_out),
    .ad_oe_o (ad_oe), .ad_i (ad_in), .ahi_o (ahi)
  );

  task automatic chk(input string tag, input int p, input logic [15:0] act, input logic [15:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s phase %0d: actual %h expected %h", tag, p, act, exp_v);
    end
  endtask

  function automatic string tag_of(input int k);
    case (k)
      K_IDLE:  return "R11";
      K_INT:   return "R6";
      K_FETCH: return "R4";
      K_READ:  return "R7";
      default: return "R8";
    endcase
  endfunction

  // One machine cycle of kind k; the next request is presented in phase 0.
  task automatic cyc(input int k, input logic [15:0] a, input logic [7:0] wd, input logic [7:0] din,
                     input logic nreq, input logic [1:0] nop, input logic [15:0] na,
                     input logic [7:0] nwd, input logic nea);
    bit ext  = (k == K_FETCH) || (k == K_READ) || (k == K_WRITE);
    bit data = (k == K_READ) || (k == K_WRITE);
    string t = tag_of(k);
    if (ext) last_hi = a[15:8];
    for (int p = 0; p < 12; p++) begin
      int  hp = p % 6;
      bit  sec = p >= 6;
      bit  e_ale, e_psen, e_rd, e_wr, e_oe, e_rv;
      @(negedge clk);
      if (p == 0) begin req = nreq; op = nop; addr = na; wdata = nwd; ea = nea; end
      if (k == K_FETCH && hp >= 3)            ad_in = sec ? ~din : din;
      else if (k == K_READ && p >= 5 && p <= 10) ad_in = din;
      else                                    ad_in = 8'h00;
      e_ale  = (hp < 2) && !(data && sec);
      e_psen = !(k == K_FETCH && hp >= 3);
      e_rd   = !(k == K_READ && p >= 5 && p <= 10);
      e_wr   = !(k == K_WRITE && p >= 5 && p <= 10);
      e_oe   = (k == K_FETCH && hp < 3) || (k == K_READ && p < 3) || (k == K_WRITE);
      e_rv   = (k == K_FETCH && p == 6) || (k == K_READ && p == 11);
      chk(data ? "R3" : (k == K_IDLE ? "R11" : "R2"), p, 16'(ale), 16'(e_ale));
      chk(t, p, 16'(psen_n), 16'(e_psen));
      chk("R7", p, 16'(rd_n), 16'(e_rd));
      chk("R8", p, 16'(wr_n), 16'(e_wr));
      chk(t, p, 16'(ad_oe), 16'(e_oe));
      if (e_oe) chk(t, p, 16'(ad_out), 16'((k == K_WRITE && p >= 4) ? wd : a[7:0]));
      chk(k == K_FETCH ? "R5" : t, p, 16'(rvalid), 16'(e_rv));
      if (e_rv) chk(k == K_FETCH ? "R5" : "R7", p, 16'(rdata), 16'(din));
      chk("R9", p, 16'(ahi), 16'(last_hi));
      chk("R10", p, 16'(ack), 16'((p == 11) && nreq));
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    chk("R1", 0, 16'(ale), 16'h0);
    chk("R1", 0, 16'({psen_n, rd_n, wr_n}), 16'h7);
    chk("R1", 0, 16'(ad_oe), 16'h0);
    chk("R1", 0, 16'(rvalid), 16'h0);
    chk("R1", 0, 16'(ack), 16'h0);
    req = 1'b0;
    rst_ni = 1'b1;
  endtask

  // First cycle after reset is idle and already at phase 0; queue an external fetch.
  task automatic t_idle_then_fetch();
    cyc(K_IDLE, 16'h0000, 8'h00, 8'h00, 1'b1, 2'b00, 16'h2345, 8'h00, 1'b1);
    cyc(K_FETCH, 16'h2345, 8'h00, 8'hA6, 1'b1, 2'b10, 16'h81C4, 8'h00, 1'b0);
  endtask

  // Read with a write queued: rvalid and ack share phase 11.
  task automatic t_read_write_b2b();
    cyc(K_READ, 16'h81C4, 8'h00, 8'h5A, 1'b1, 2'b11, 16'h1234, 8'hC3, 1'b0);
    cyc(K_WRITE, 16'h1234, 8'hC3, 8'h00, 1'b1, 2'b00, 16'h0100, 8'h00, 1'b1);
  endtask

  // Internal space boundary: 0x0100 and 0x1FFF internal, 0x2000 external, ea low external.
  task automatic t_internal_limit();
    cyc(K_INT, 16'h0100, 8'h00, 8'h00, 1'b1, 2'b00, 16'h0100, 8'h00, 1'b0);
    cyc(K_FETCH, 16'h0100, 8'h00, 8'h3C, 1'b1, 2'b00, 16'h2000, 8'h00, 1'b1);
    cyc(K_FETCH, 16'h2000, 8'h00, 8'h81, 1'b1, 2'b00, 16'h1FFF, 8'h00, 1'b1);
    cyc(K_INT, 16'h1FFF, 8'h00, 8'h00, 1'b0, 2'b00, 16'h0000, 8'h00, 1'b0);
  endtask

  // Op code 01 is a fetch; the idle cycles around it keep the port quiet.
  task automatic t_alt_fetch_code();
    cyc(K_IDLE, 16'h0000, 8'h00, 8'h00, 1'b1, 2'b01, 16'hFF00, 8'h99, 1'b0);
    cyc(K_FETCH, 16'hFF00, 8'h00, 8'hE7, 1'b0, 2'b00, 16'h0000, 8'h00, 1'b0);
    cyc(K_IDLE, 16'h0000, 8'h00, 8'h00, 1'b0, 2'b00, 16'h0000, 8'h00, 1'b0);
  endtask

  initial begin
    t_reset();
    t_idle_then_fetch();
    t_read_write_b2b();
    t_internal_limit();
    t_alt_fetch_code();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule